// File: doc/BRIEF.md
# Linked-List Pointer Stack Unit

This block keeps eight independent last-in-first-out lists of buffer pointers, such as pools of free packet buffers shared by several processors. The unit stores only one head register per list. The chain of older entries is threaded through a link memory: each pushed buffer's own word holds the pointer that was on top before it. A single sequencer runs every command, so a push or pop on any list completes before the next command is accepted. This makes each operation atomic for all requesters.

A command arrives in one of two forms. In direct form, the requester gives an operation bit, a list number and two operands, and the pushed pointer is their sum. In aliased form, a byte address selects both the operation and the list, while the operands still supply the pushed pointer. A pop answers with the head pointer, or with an empty indication when the list holds nothing. An aliased address outside both regions is answered with an error and changes nothing.

Top module: `llq_stack_unit`

## Requirements
- R1: After reset every list is empty, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A push stores the pointer `(cmd_opa + cmd_opb) mod 2^PTR_W` as the new head of the selected list and answers with that pointer in `rsp_ptr`, with `rsp_empty` = 0 and `rsp_err` = 0.
- R3: A pop on a non-empty list answers with the most recently pushed pointer that has not yet been popped, so the lists are last-in-first-out. A pointer value of 0 is a legal entry.
- R4: A pop on an empty list answers with `rsp_ptr` = 0 and `rsp_empty` = 1, and it leaves that list unchanged.
- R5: Operations on one list do not change the contents or the order of any other list.
- R6: When `cmd_alias` = 1, `cmd_op` and `cmd_list` are ignored. Byte addresses `0x2000_0000 + n*0x0080_0000` through the end of that 8 MB slice push onto list n. Byte addresses `0x2400_0000 + n*0x0080_0000` through the end of that slice pop from list n. The offset inside a slice has no effect.
- R7: An aliased address outside both 64 MB regions answers with `rsp_err` = 1, `rsp_ptr` = 0 and `rsp_empty` = 0, and it leaves every list unchanged.
- R8: `cmd_ready` drops in the cycle after a command is accepted. It stays low until the response, and each accepted command produces exactly one response.
- R9: `rsp_valid` is high for exactly one cycle. The response comes one clock after acceptance for a push, an empty pop or an error, and two clocks after acceptance for a non-empty pop.
- R10: In direct form, `cmd_op` = 1 selects push and `cmd_op` = 0 selects pop, and `cmd_list` names the list from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle; command accepted when both are high |
| cmd_alias | input | 1 | 1: decode operation and list from `cmd_addr` |
| cmd_op | input | 1 | Direct form: 1 push, 0 pop |
| cmd_list | input | LIST_W (3) | Direct form: list number |
| cmd_opa | input | OPND_W (32) | First operand of the pushed pointer |
| cmd_opb | input | OPND_W (32) | Second operand of the pushed pointer |
| cmd_addr | input | ADDR_W (32) | Aliased byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ptr | output | PTR_W (8) | Pushed or popped pointer, 0 when empty or on error |
| rsp_empty | output | 1 | Pop found the list empty |
| rsp_err | output | 1 | Aliased address decoded to no region |

## Verification
The bench builds the unit with its default parameters: eight lists, 8-bit pointers and 32-bit operands and addresses. A 256-word link memory lets the bench load every list with several distinct pointers at once and drain them all in reverse order. The alias sweep covers both regions of every one of the eight slices, using offsets at both ends of each slice, and probes addresses just outside the regions. Operand pairs whose sum overflows 32 bits check the wrap to the pointer width. Expected pointers come from the arithmetic that assigned them.

// File: rtl/llq_pkg.sv
package llq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_FETCH = 2'd2
    } llq_state_e;

    localparam logic OP_POP  = 1'b0;
    localparam logic OP_PUSH = 1'b1;

endpackage

// File: rtl/llq_alias_decode.sv
module llq_alias_decode #(
    parameter int ADDR_W      = 32,
    parameter int NUM_LISTS   = 8,
    parameter int LIST_W      = 3,
    parameter int SLICE_LOG2  = 23,
    parameter logic [ADDR_W-1:0] PUSH_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] POP_BASE  = 32'h2400_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_push,
    output logic [LIST_W-1:0] list
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_LISTS) << SLICE_LOG2;

    logic [ADDR_W-1:0] push_off;
    logic [ADDR_W-1:0] pop_off;
    logic              in_push;
    logic              in_pop;

    always_comb begin
        push_off = addr - PUSH_BASE;
        pop_off  = addr - POP_BASE;
        in_push  = (addr >= PUSH_BASE) && (push_off < SPAN);
        in_pop   = (addr >= POP_BASE)  && (pop_off  < SPAN);
        hit      = in_push || in_pop;
        is_push  = in_push;
        if (in_push) begin
            list = push_off[SLICE_LOG2 +: LIST_W];
        end else begin
            list = pop_off[SLICE_LOG2 +: LIST_W];
        end
    end

endmodule

// File: rtl/llq_head_file.sv
module llq_head_file #(
    parameter int NUM_LISTS = 8,
    parameter int LIST_W    = 3,
    parameter int PTR_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [LIST_W-1:0]          wr_list,
    input  logic                       wr_vld,
    input  logic [PTR_W-1:0]           wr_ptr,
    input  logic [LIST_W-1:0]          rd_list,
    output logic                       rd_vld,
    output logic [PTR_W-1:0]           rd_ptr,
    output logic [NUM_LISTS-1:0]       all_vld,
    output logic [NUM_LISTS*PTR_W-1:0] all_ptr
);
    logic [NUM_LISTS-1:0] vld_q;
    logic [PTR_W-1:0]     ptr_q [NUM_LISTS];

    for (genvar g = 0; g < NUM_LISTS; g++) begin : g_head
        logic             vld_d;
        logic [PTR_W-1:0] ptr_d;

        always_comb begin
            vld_d = vld_q[g];
            ptr_d = ptr_q[g];
            if (wr_en && (wr_list == LIST_W'(g))) begin
                vld_d = wr_vld;
                ptr_d = wr_ptr;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                ptr_q[g] <= '0;
            end else begin
                vld_q[g] <= vld_d;
                ptr_q[g] <= ptr_d;
            end
        end

        assign all_ptr[g*PTR_W +: PTR_W] = ptr_q[g];
    end

    assign all_vld = vld_q;
    assign rd_vld  = vld_q[rd_list];
    assign rd_ptr  = ptr_q[rd_list];

endmodule

// File: rtl/llq_link_ram.sv
module llq_link_ram #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/llq_stack_unit.sv
module llq_stack_unit
    import llq_pkg::*;
#(
    parameter int NUM_LISTS  = 8,
    parameter int PTR_W      = 8,
    parameter int OPND_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int SLICE_LOG2 = 23,
    parameter logic [ADDR_W-1:0] PUSH_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] POP_BASE  = 32'h2400_0000,
    localparam int LIST_W = $clog2(NUM_LISTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_alias,
    input  logic              cmd_op,
    input  logic [LIST_W-1:0] cmd_list,
    input  logic [OPND_W-1:0] cmd_opa,
    input  logic [OPND_W-1:0] cmd_opb,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              rsp_valid,
    output logic [PTR_W-1:0]  rsp_ptr,
    output logic              rsp_empty,
    output logic              rsp_err
);
    localparam int LINK_W = PTR_W + 1;

    typedef struct packed {
        llq_state_e        state;
        logic              is_push;
        logic [LIST_W-1:0] list;
        logic [PTR_W-1:0]  ptr;
        logic              err;
        logic              rsp_valid;
        logic [PTR_W-1:0]  rsp_ptr;
        logic              rsp_empty;
        logic              rsp_err;
    } seq_t;

    seq_t seq_d, seq_q;

    // alias decode
    logic              dec_hit;
    logic              dec_push;
    logic [LIST_W-1:0] dec_list;

    llq_alias_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_LISTS  (NUM_LISTS),
        .LIST_W     (LIST_W),
        .SLICE_LOG2 (SLICE_LOG2),
        .PUSH_BASE  (PUSH_BASE),
        .POP_BASE   (POP_BASE)
    ) dec_i (
        .addr    (cmd_addr),
        .hit     (dec_hit),
        .is_push (dec_push),
        .list    (dec_list)
    );

    // operand sum, wrapped to the pointer width
    logic [OPND_W-1:0] opnd_sum;
    logic              unused_sum_hi;
    assign opnd_sum      = cmd_opa + cmd_opb;
    assign unused_sum_hi = ^opnd_sum[OPND_W-1:PTR_W];

    // head registers
    logic                       head_we;
    logic                       head_wr_vld;
    logic [PTR_W-1:0]           head_wr_ptr;
    logic                       head_rd_vld;
    logic [PTR_W-1:0]           head_rd_ptr;
    logic [NUM_LISTS-1:0]       head_all_vld;
    logic [NUM_LISTS*PTR_W-1:0] head_all_ptr;

    llq_head_file #(
        .NUM_LISTS (NUM_LISTS),
        .LIST_W    (LIST_W),
        .PTR_W     (PTR_W)
    ) heads_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (head_we),
        .wr_list (seq_q.list),
        .wr_vld  (head_wr_vld),
        .wr_ptr  (head_wr_ptr),
        .rd_list (seq_q.list),
        .rd_vld  (head_rd_vld),
        .rd_ptr  (head_rd_ptr),
        .all_vld (head_all_vld),
        .all_ptr (head_all_ptr)
    );

    // link memory: word at a buffer address holds {next_valid, next_ptr}
    logic              link_we;
    logic [PTR_W-1:0]  link_waddr;
    logic [LINK_W-1:0] link_wdata;
    logic              link_re;
    logic [PTR_W-1:0]  link_raddr;
    logic [LINK_W-1:0] link_rdata;

    llq_link_ram #(
        .AW (PTR_W),
        .DW (LINK_W)
    ) links_i (
        .clk   (clk),
        .we    (link_we),
        .waddr (link_waddr),
        .wdata (link_wdata),
        .re    (link_re),
        .raddr (link_raddr),
        .rdata (link_rdata)
    );

    // next-state logic
    always_comb begin
        seq_d           = seq_q;
        seq_d.rsp_valid = 1'b0;
        head_we         = 1'b0;
        head_wr_vld     = 1'b0;
        head_wr_ptr     = '0;
        link_we         = 1'b0;
        link_waddr      = seq_q.ptr;
        link_wdata      = {head_rd_vld, head_rd_ptr};
        link_re         = 1'b0;
        link_raddr      = head_rd_ptr;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    seq_d.state = ST_EXEC;
                    seq_d.ptr   = opnd_sum[PTR_W-1:0];
                    if (cmd_alias) begin
                        seq_d.is_push = dec_push;
                        seq_d.list    = dec_list;
                        seq_d.err     = !dec_hit;
                    end else begin
                        seq_d.is_push = (cmd_op == OP_PUSH);
                        seq_d.list    = cmd_list;
                        seq_d.err     = 1'b0;
                    end
                end
            end
            ST_EXEC: begin
                if (seq_q.err) begin
                    seq_d.state     = ST_IDLE;
                    seq_d.rsp_valid = 1'b1;
                    seq_d.rsp_ptr   = '0;
                    seq_d.rsp_empty = 1'b0;
                    seq_d.rsp_err   = 1'b1;
                end else if (seq_q.is_push) begin
                    link_we         = 1'b1;
                    head_we         = 1'b1;
                    head_wr_vld     = 1'b1;
                    head_wr_ptr     = seq_q.ptr;
                    seq_d.state     = ST_IDLE;
                    seq_d.rsp_valid = 1'b1;
                    seq_d.rsp_ptr   = seq_q.ptr;
                    seq_d.rsp_empty = 1'b0;
                    seq_d.rsp_err   = 1'b0;
                end else if (!head_rd_vld) begin
                    seq_d.state     = ST_IDLE;
                    seq_d.rsp_valid = 1'b1;
                    seq_d.rsp_ptr   = '0;
                    seq_d.rsp_empty = 1'b1;
                    seq_d.rsp_err   = 1'b0;
                end else begin
                    link_re     = 1'b1;
                    seq_d.ptr   = head_rd_ptr;
                    seq_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                head_we         = 1'b1;
                head_wr_vld     = link_rdata[PTR_W];
                head_wr_ptr     = link_rdata[PTR_W-1:0];
                seq_d.state     = ST_IDLE;
                seq_d.rsp_valid = 1'b1;
                seq_d.rsp_ptr   = seq_q.ptr;
                seq_d.rsp_empty = 1'b0;
                seq_d.rsp_err   = 1'b0;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready = (seq_q.state == ST_IDLE);
    assign rsp_valid = seq_q.rsp_valid;
    assign rsp_ptr   = seq_q.rsp_ptr;
    assign rsp_empty = seq_q.rsp_empty;
    assign rsp_err   = seq_q.rsp_err;

    // R9: response strobe lasts one cycle
    a_r9_rsp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: empty answer carries a zero pointer and no error
    a_r4_empty_zero_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_empty) |-> (rsp_ptr == '0) && !rsp_err);

    // R2: a push leaves its pointer on top of its list
    a_r2_push_sets_head: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_EXEC && seq_q.is_push && !seq_q.err) |=>
            head_all_vld[seq_q.list] &&
            (head_all_ptr[seq_q.list*PTR_W +: PTR_W] == seq_q.ptr));

    // R7: an unmapped alias address touches no head
    a_r7_err_keeps_heads: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_EXEC && seq_q.err) |=>
            $stable(head_all_vld) && $stable(head_all_ptr));

    // R8: acceptance makes the sequencer busy
    a_r8_accept_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R8: a response coincides with the return to idle
    a_r8_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cmd_ready);

    // R3: a link fetch always ends in a non-empty answer
    a_r3_fetch_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_FETCH) |=> rsp_valid && !rsp_empty && !rsp_err);

endmodule

// File: tb/llq_stack_unit_tb.sv
module llq_stack_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PUSH_AL = 32'h2000_0000;
    localparam logic [31:0] POP_AL  = 32'h2400_0000;
    localparam logic [31:0] SLICE   = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_alias = 1'b0;
    logic        cmd_op = 1'b0;
    logic [2:0]  cmd_list = '0;
    logic [31:0] cmd_opa = '0;
    logic [31:0] cmd_opb = '0;
    logic [31:0] cmd_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_ptr;
    logic        rsp_empty;
    logic        rsp_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llq_stack_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_alias (cmd_alias),
        .cmd_op    (cmd_op),
        .cmd_list  (cmd_list),
        .cmd_opa   (cmd_opa),
        .cmd_opb   (cmd_opb),
        .cmd_addr  (cmd_addr),
        .rsp_valid (rsp_valid),
        .rsp_ptr   (rsp_ptr),
        .rsp_empty (rsp_empty),
        .rsp_err   (rsp_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // r_ptr, r_emp, r_err, latency in clocks after acceptance
    task automatic issue(input logic al, input logic op, input logic [2:0] li,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] ad,
                         output int r_ptr, output int r_emp, output int r_err,
                         output int lat);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_alias = al;
        cmd_op    = op;
        cmd_list  = li;
        cmd_opa   = a;
        cmd_opb   = b;
        cmd_addr  = ad;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 busy after accept", int'(cmd_ready), 0);
        lat = 0;
        while (lat < 8) begin
            @(negedge clk);
            lat++;
            if (rsp_valid) break;
        end
        r_ptr = int'(rsp_ptr);
        r_emp = int'(rsp_empty);
        r_err = int'(rsp_err);
        @(negedge clk);
        chk("R9 strobe one cycle", int'(rsp_valid), 0);
    endtask

    task automatic push_chk(input string req, input logic al, input logic [2:0] li,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] ad, input int exp_ptr);
        int p, e, r, l;
        issue(al, 1'b1, li, a, b, ad, p, e, r, l);
        chk({req, " push ptr"}, p, exp_ptr);
        chk({req, " push flags"}, e * 2 + r, 0);
        chk("R9 push latency", l, 1);
    endtask

    task automatic pop_chk(input string req, input logic al, input logic [2:0] li,
                           input logic [31:0] ad, input int exp_ptr, input int exp_emp);
        int p, e, r, l;
        issue(al, 1'b0, li, 32'h0, 32'h0, ad, p, e, r, l);
        chk({req, " pop ptr"}, p, exp_ptr);
        chk({req, " pop empty"}, e, exp_emp);
        chk({req, " pop err"}, r, 0);
        chk("R9 pop latency", l, exp_emp ? 1 : 2);
    endtask

    task automatic err_chk(input logic [31:0] ad);
        int p, e, r, l;
        issue(1'b1, 1'b1, 3'd3, 32'h55, 32'h0, ad, p, e, r, l);
        chk("R7 err flag", r, 1);
        chk("R7 err ptr", p, 0);
        chk("R7 err empty", e, 0);
        chk("R9 err latency", l, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 no rsp", int'(rsp_valid), 0);
        for (int l = 0; l < 8; l++) pop_chk("R1 empty after reset", 1'b0, 3'(l), 0, 0, 1);

        // R2 R10 direct pushes: list l gets pointers l*16+k
        for (int l = 0; l < 8; l++)
            for (int k = 0; k < 6; k++)
                push_chk("R2", 1'b0, 3'(l), 32'(l*16), 32'(k), 0, l*16 + k);

        // R3 R5 drain in reverse order (pointer 0 is a legal entry)
        for (int l = 7; l >= 0; l--)
            for (int k = 5; k >= 0; k--)
                pop_chk("R3", 1'b0, 3'(l), 0, l*16 + k, 0);

        // R4 every list now empty
        for (int l = 0; l < 8; l++) pop_chk("R4 drained", 1'b0, 3'(l), 0, 0, 1);

        // R5 interleaved lists
        push_chk("R5", 1'b0, 3'd2, 32'h90, 32'h1, 0, 8'h91);
        push_chk("R5", 1'b0, 3'd5, 32'h90, 32'h2, 0, 8'h92);
        push_chk("R5", 1'b0, 3'd2, 32'h90, 32'h3, 0, 8'h93);
        pop_chk("R5", 1'b0, 3'd5, 0, 8'h92, 0);
        pop_chk("R5", 1'b0, 3'd2, 0, 8'h93, 0);
        pop_chk("R5", 1'b0, 3'd2, 0, 8'h91, 0);
        pop_chk("R5", 1'b0, 3'd5, 0, 0, 1);

        // R2 sum wraps past 32 bits and is cut to 8 bits
        push_chk("R2 wrap", 1'b0, 3'd1, 32'hFFFF_FF00, 32'h0000_01F3, 0, 8'hF3);
        pop_chk("R2 wrap", 1'b0, 3'd1, 0, 8'hF3, 0);

        // R6 alias: cmd_op=0 and cmd_list ignored, offset inside slice ignored
        for (int n = 0; n < 8; n++) begin
            int p, e, r, l;
            issue(1'b1, 1'b0, 3'(7 - n), 32'(8'hA0 + n), 32'h0,
                  PUSH_AL + 32'(n) * SLICE + 32'h0000_1234, p, e, r, l);
            chk("R6 alias push ptr", p, 8'hA0 + n);
            chk("R6 alias push flags", e * 2 + r, 0);
        end
        for (int n = 0; n < 8; n++) begin
            int p, e, r, l;
            issue(1'b1, 1'b1, 3'(7 - n), 32'h0, 32'h0,
                  POP_AL + 32'(n) * SLICE + SLICE - 32'd4, p, e, r, l);
            chk("R6 alias pop ptr", p, 8'hA0 + n);
            chk("R6 alias pop empty", e, 0);
            chk("R6 alias pop latency", l, 2);
        end
        for (int n = 0; n < 8; n++) pop_chk("R6 alias drained", 1'b1, 3'd0, POP_AL + 32'(n) * SLICE, 0, 1);

        // R7 unmapped addresses leave lists intact
        push_chk("R7 setup", 1'b0, 3'd3, 32'hC0, 32'h0, 0, 8'hC0);
        err_chk(32'h1FFF_FFFC);
        err_chk(32'h2800_0000);
        err_chk(32'h0000_0000);
        pop_chk("R7 list kept", 1'b0, 3'd3, 0, 8'hC0, 0);
        for (int l = 0; l < 8; l++) pop_chk("R7 nothing added", 1'b0, 3'(l), 0, 0, 1);

        // R4 empty pop leaves the list usable
        pop_chk("R4 empty", 1'b0, 3'd6, 0, 0, 1);
        push_chk("R4 after empty", 1'b0, 3'd6, 32'h40, 32'h2, 0, 8'h42);
        pop_chk("R4 after empty", 1'b0, 3'd6, 0, 8'h42, 0);
        pop_chk("R4 empty again", 1'b0, 3'd6, 0, 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule